// File: doc/BRIEF.md
# Pushbutton Debounced Reset Generator

This block turns a pushbutton line and a digital power-good flag into a system reset. The pushbutton is active low and reads high when nobody touches it. It passes through a two-flop synchroniser and then a debouncer. A press counts as valid only once the synchronised line has stayed low across a parameterised number of millisecond ticks. The power-good flag is synchronised the same way.

While a valid press is held, or while power is out of tolerance, the block asserts a pair of reset outputs of opposite polarity. When the holding condition clears, a shared stretch timer keeps reset asserted for a further fixed number of milliseconds. A new press or a new power fault during the stretch sends the timer back to zero. It starts counting again when that condition clears.

All timing is derived from a free-running clock through a millisecond prescaler. The cycles per tick, the debounce length and the stretch length are parameters, so a bench can scale them down. A synchronous active-high system reset clears every counter and forces the outputs asserted until one full stretch has elapsed.

Top module: `pb_reset_gen`

## Requirements
- R1: With the button high and power good, once reset has been released it stays deasserted for as long as neither input changes.
- R2: A button low level held for at least (DEBOUNCE_MS+1)*TICK_CYCLES+5 cycles asserts reset. Reset rises no earlier than DEBOUNCE_MS*TICK_CYCLES+1 and no later than (DEBOUNCE_MS+1)*TICK_CYCLES+5 cycles after the line goes low.
- R3: A button low pulse shorter than DEBOUNCE_MS*TICK_CYCLES-2 cycles never asserts reset.
- R4: After the button returns high, reset stays asserted for at least STRETCH_MS*TICK_CYCLES+1 cycles and is released within (STRETCH_MS+1)*TICK_CYCLES+5 cycles.
- R5: A low level on pwr_good asserts reset within 3 clock cycles and holds it while pwr_good stays low.
- R6: After pwr_good returns high, reset is stretched with the same bounds as in R4, measured from the rising edge of pwr_good.
- R7: rst_out_n is always the inverse of rst_out (rst_out=1 means reset asserted).
- R8: While sys_rst is high, rst_out is 1 from the next cycle on. After sys_rst falls, reset is released only after a full stretch, with the same bounds as in R4.
- R9: A valid press or a power fault during a running stretch restarts the stretch. Release then follows the bounds of R4, measured from the moment the new condition clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| sys_rst | input | 1 | Synchronous active-high system reset |
| btn_n | input | 1 | Pushbutton line, active low, idle high |
| pwr_good | input | 1 | Supply in tolerance when high |
| rst_out | output | 1 | Reset, active high |
| rst_out_n | output | 1 | Reset, active low |

## Verification
The assertions assume that sys_rst is high from time zero for at least one edge. This keeps every synchroniser and counter in a known state before any history-based property is evaluated. The stimulus respects this by holding sys_rst during the first cycles.

They also assume that btn_n and pwr_good change once per clock at most, so the synchronised levels follow the pins cycle for cycle. The stimulus drives both pins only on falling clock edges and holds each level for many cycles. The stimulus places the deliberate short pulse well below the debounce window, so that the properties never see a case on the boundary.

// File: rtl/pb_reset_pkg.sv
package pb_reset_pkg;

    typedef enum logic [1:0] {
        STR_HOLD = 2'd0,
        STR_WAIT = 2'd1,
        STR_DONE = 2'd2
    } stretch_st_t;

    typedef struct packed {
        logic btn_held;
        logic pwr_fault;
    } hold_src_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        int unsigned w;
        w = $clog2(max_val + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/pb_ms_tick.sv
module pb_ms_tick #(
    parameter int unsigned TICK_CYCLES = 50000
) (
    input  logic clk,
    input  logic sys_rst,
    output logic tick
);
    localparam int unsigned TW = pb_reset_pkg::cnt_width(TICK_CYCLES - 1);
    localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

    logic [TW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/pb_input_cond.sv
module pb_input_cond #(
    parameter int unsigned DEBOUNCE_MS = 16
) (
    input  logic                     clk,
    input  logic                     sys_rst,
    input  logic                     tick,
    input  logic                     btn_n,
    input  logic                     pwr_good,
    output logic                     btn_lvl,
    output logic                     pwr_ok,
    output pb_reset_pkg::hold_src_t  hold
);
    localparam int unsigned DW = pb_reset_pkg::cnt_width(DEBOUNCE_MS);
    localparam logic [DW-1:0] DLIM = DW'(DEBOUNCE_MS);

    logic [1:0]    btn_sync_q;
    logic [1:0]    pg_sync_q;
    logic [DW-1:0] low_cnt_q;
    logic          pressed_q;

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            btn_sync_q <= 2'b11;
            pg_sync_q  <= 2'b00;
            low_cnt_q  <= '0;
            pressed_q  <= 1'b0;
        end else begin
            btn_sync_q <= {btn_sync_q[0], btn_n};
            pg_sync_q  <= {pg_sync_q[0], pwr_good};
            if (btn_sync_q[1]) begin
                low_cnt_q <= '0;
                pressed_q <= 1'b0;
            end else if (tick && !pressed_q) begin
                if (low_cnt_q == DLIM) begin
                    pressed_q <= 1'b1;
                end else begin
                    low_cnt_q <= low_cnt_q + 1'b1;
                end
            end
        end
    end

    assign btn_lvl        = btn_sync_q[1];
    assign pwr_ok         = pg_sync_q[1];
    assign hold.btn_held  = pressed_q;
    assign hold.pwr_fault = ~pg_sync_q[1];
endmodule

// File: rtl/pb_stretch.sv
module pb_stretch #(
    parameter int unsigned STRETCH_MS = 250
) (
    input  logic                     clk,
    input  logic                     sys_rst,
    input  logic                     tick,
    input  pb_reset_pkg::hold_src_t  hold,
    output logic                     rst_out,
    output logic                     rst_out_n
);
    import pb_reset_pkg::*;

    localparam int unsigned SW = cnt_width(STRETCH_MS);
    localparam logic [SW-1:0] SLIM = SW'(STRETCH_MS);

    stretch_st_t   st_q, st_d;
    logic [SW-1:0] cnt_q, cnt_d;
    logic          held;

    assign held = hold.btn_held | hold.pwr_fault;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (held) begin
            st_d  = STR_HOLD;
            cnt_d = '0;
        end else begin
            case (st_q)
                STR_HOLD: begin
                    st_d  = STR_WAIT;
                    cnt_d = '0;
                end
                STR_WAIT: begin
                    if (tick) begin
                        if (cnt_q == SLIM) begin
                            st_d = STR_DONE;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: st_d = STR_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            st_q      <= STR_HOLD;
            cnt_q     <= '0;
            rst_out   <= 1'b1;
            rst_out_n <= 1'b0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            rst_out   <= (st_d != STR_DONE);
            rst_out_n <= (st_d == STR_DONE);
        end
    end
endmodule

// File: rtl/pb_reset_gen.sv
module pb_reset_gen #(
    parameter int unsigned TICK_CYCLES = 50000,
    parameter int unsigned DEBOUNCE_MS = 16,
    parameter int unsigned STRETCH_MS  = 250
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic btn_n,
    input  logic pwr_good,
    output logic rst_out,
    output logic rst_out_n
);
    pb_reset_pkg::hold_src_t hold;
    logic tick;
    logic btn_lvl;
    logic pwr_ok;

    pb_ms_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk     (clk),
        .sys_rst (sys_rst),
        .tick    (tick)
    );

    pb_input_cond #(.DEBOUNCE_MS(DEBOUNCE_MS)) u_cond (
        .clk      (clk),
        .sys_rst  (sys_rst),
        .tick     (tick),
        .btn_n    (btn_n),
        .pwr_good (pwr_good),
        .btn_lvl  (btn_lvl),
        .pwr_ok   (pwr_ok),
        .hold     (hold)
    );

    pb_stretch #(.STRETCH_MS(STRETCH_MS)) u_stretch (
        .clk       (clk),
        .sys_rst   (sys_rst),
        .tick      (tick),
        .hold      (hold),
        .rst_out   (rst_out),
        .rst_out_n (rst_out_n)
    );
endmodule

// File: rtl/pb_reset_chk.sv
module pb_reset_chk #(
    parameter int unsigned TICK_CYCLES = 50000,
    parameter int unsigned DEBOUNCE_MS = 16,
    parameter int unsigned STRETCH_MS  = 250
) (
    input logic clk,
    input logic sys_rst,
    input logic tick,
    input logic btn_lvl,
    input logic pressed,
    input logic pwr_ok,
    input logic rst_out
);
    localparam int unsigned MIN_STRETCH = STRETCH_MS * TICK_CYCLES;
    localparam int unsigned MIN_DEB     = DEBOUNCE_MS * TICK_CYCLES;
    localparam int unsigned CW = pb_reset_pkg::cnt_width(MIN_STRETCH + MIN_DEB + 2);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] quiet_q;
    logic [CW-1:0] low_q;

    always_ff @(posedge clk) begin
        if (sys_rst || pressed || !pwr_ok) begin
            quiet_q <= '0;
        end else if (quiet_q != CMAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
        if (sys_rst || btn_lvl) begin
            low_q <= '0;
        end else if (low_q != CMAX) begin
            low_q <= low_q + 1'b1;
        end
    end

    // R2: a debounced press forces reset on the next edge
    p_press_asserts_r2: assert property (@(posedge clk) disable iff (sys_rst)
        pressed |=> rst_out);

    // R3: a press is only recognised after the full debounce window
    p_debounce_min_r3: assert property (@(posedge clk) disable iff (sys_rst)
        $rose(pressed) |-> (low_q >= CW'(MIN_DEB)));

    // R4: release never comes before the full stretch
    p_stretch_min_r4: assert property (@(posedge clk) disable iff (sys_rst)
        $fell(rst_out) |-> (quiet_q >= CW'(MIN_STRETCH)));

    // R4: release happens on a millisecond boundary
    p_release_on_tick_r4: assert property (@(posedge clk) disable iff (sys_rst)
        $fell(rst_out) |-> $past(tick));

    // R5: a synchronised power fault forces reset on the next edge
    p_fault_asserts_r5: assert property (@(posedge clk) disable iff (sys_rst)
        !pwr_ok |=> rst_out);

    // R8: system reset forces reset asserted
    p_sysrst_asserts_r8: assert property (@(posedge clk)
        sys_rst |=> rst_out);
endmodule

bind pb_reset_gen pb_reset_chk #(
    .TICK_CYCLES (TICK_CYCLES),
    .DEBOUNCE_MS (DEBOUNCE_MS),
    .STRETCH_MS  (STRETCH_MS)
) u_chk (
    .clk     (clk),
    .sys_rst (sys_rst),
    .tick    (tick),
    .btn_lvl (btn_lvl),
    .pressed (hold.btn_held),
    .pwr_ok  (pwr_ok),
    .rst_out (rst_out)
);

// File: tb/pb_reset_gen_bench.sv
module pb_reset_gen_bench;
    localparam int unsigned T   = 10;
    localparam int unsigned DEB = 3;
    localparam int unsigned STR = 8;
    localparam int unsigned STR_MIN = STR * T + 1;
    localparam int unsigned STR_MAX = (STR + 1) * T + 5;
    localparam int unsigned DEB_MIN = DEB * T + 1;
    localparam int unsigned DEB_MAX = (DEB + 1) * T + 5;

    logic clk = 1'b0;
    logic sys_rst = 1'b1;
    logic btn_n = 1'b1;
    logic pwr_good = 1'b1;
    logic rst_out, rst_out_n;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    pb_reset_gen #(.TICK_CYCLES(T), .DEBOUNCE_MS(DEB), .STRETCH_MS(STR)) u_pb_reset_gen (
        .clk(clk), .sys_rst(sys_rst), .btn_n(btn_n), .pwr_good(pwr_good),
        .rst_out(rst_out), .rst_out_n(rst_out_n)
    );

    task automatic check(input string req, input int act, input int exp_lo, input int exp_hi);
        n_checks++;
        if (act < exp_lo || act > exp_hi) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=[%0d..%0d]", req, act, exp_lo, exp_hi);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts falling edges until rst_out reaches lvl, capped at limit+1
    task automatic time_to(input logic lvl, input int limit, output int n);
        n = 0;
        while (rst_out !== lvl && n <= limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_sysrst();
        int n;
        @(negedge clk);
        sys_rst = 1'b1;
        cycles(3);
        check("R8 held in reset", int'(rst_out), 1, 1);
        check("R7 inverse in reset", int'(rst_out_n), 0, 0);
        sys_rst = 1'b0;
        time_to(1'b0, STR_MAX + 5, n);
        check("R8 release after sys_rst", n, STR_MIN, STR_MAX);
        check("R7 inverse after release", int'(rst_out_n), 1, 1);
    endtask

    task automatic t_idle();
        int bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rst_out !== 1'b0 || rst_out_n !== 1'b1) bad++;
        end
        check("R1 idle stays released", bad, 0, 0);
    endtask

    task automatic t_press();
        int n;
        btn_n = 1'b0;
        time_to(1'b1, DEB_MAX + 5, n);
        check("R2 press assert latency", n, DEB_MIN, DEB_MAX);
        check("R7 inverse while pressed", int'(rst_out_n), 0, 0);
        cycles(100);
        check("R2 held while pressed", int'(rst_out), 1, 1);
        btn_n = 1'b1;
        time_to(1'b0, STR_MAX + 5, n);
        check("R4 stretch after release", n, STR_MIN, STR_MAX);
    endtask

    task automatic t_glitch();
        int seen = 0;
        btn_n = 1'b0;
        cycles(DEB * T - 5);
        btn_n = 1'b1;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (rst_out !== 1'b0) seen++;
        end
        check("R3 short pulse ignored", seen, 0, 0);
    endtask

    task automatic t_repress();
        int n;
        btn_n = 1'b0;
        cycles(DEB_MAX + 5);
        btn_n = 1'b1;
        cycles(40);
        check("R9 still stretching", int'(rst_out), 1, 1);
        btn_n = 1'b0;
        cycles(DEB_MAX + 5);
        btn_n = 1'b1;
        time_to(1'b0, STR_MAX + 5, n);
        check("R9 restart after re-press", n, STR_MIN, STR_MAX);
    endtask

    task automatic t_power();
        int n;
        pwr_good = 1'b0;
        time_to(1'b1, 6, n);
        check("R5 fault assert latency", n, 1, 3);
        cycles(50);
        check("R5 held during fault", int'(rst_out), 1, 1);
        pwr_good = 1'b1;
        time_to(1'b0, STR_MAX + 5, n);
        check("R6 stretch after power return", n, STR_MIN, STR_MAX);
    endtask

    task automatic t_fault_in_stretch();
        int n;
        btn_n = 1'b0;
        cycles(DEB_MAX + 5);
        btn_n = 1'b1;
        cycles(50);
        pwr_good = 1'b0;
        cycles(10);
        pwr_good = 1'b1;
        time_to(1'b0, STR_MAX + 5, n);
        check("R9 restart after fault in stretch", n, STR_MIN, STR_MAX);
    endtask

    initial begin
        cycles(2);
        t_sysrst();
        t_idle();
        t_press();
        t_glitch();
        t_repress();
        t_power();
        t_fault_in_stretch();
        t_sysrst();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule